// File: doc/BRIEF.md
# PLL Divider Setting Search Engine

This block takes a requested output frequency and a reference frequency, both unsigned integers in MHz, and looks for the PLL setting whose output comes closest to the request without going over it. A setting has three fields: an 8-bit multiplier code `m`, a one-bit input halver `h` and a 3-bit power-of-two output shift `s`. The output frequency is `floor(ref * (m+1) / ((h+1) * 2^s))`. Because both dividers are powers of two, this equals `(ref * (m+1)) >> (h+s)`.

A one-cycle `start_i` pulse latches both rates. The engine then tests one candidate per clock. The order is fixed: `h` steps from 1 down to 0; inside that, `s` steps from 7 down to 0; inside that, `m` steps from 0 up to 255. This gives at most 4096 candidates. The search stops at the first candidate with zero error. Otherwise it keeps the lowest error, and the earliest candidate wins a tie. When the search ends, `done_o` pulses and the engine reports the fields, the error, an exact flag, a no-fit flag and a loop-filter code. The filter code is chosen from the halved-or-not reference frequency.

The controller has three states. IDLE waits for a start. SCAN evaluates candidates. REPORT is the single cycle in which `done_o` is high. The transitions are:
- IDLE→SCAN when `start_i` is high.
- SCAN→SCAN while candidates remain and none is exact.
- SCAN→REPORT on an exact hit or after the last candidate.
- REPORT→IDLE unconditionally.

Top module: `pll_search_engine`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `exact_o` and `nofit_o` are 0, and `word_o`, `err_o` and all field outputs are 0.
- R2: When a fit exists, the reported setting gives `(ref*(mul_o+1)) >> (pre_o+post_o)` equal to `req - err_o`, so the output never exceeds the request.
- R3: The reported setting has the lowest error of all 4096 candidates. On equal error, the one that comes first in the order (halver 1→0, shift 7→0, multiplier 0→255) is reported.
- R4: On the first zero-error candidate the search stops and `exact_o`=1. For a start accepted at edge E, `done_o` is high after edge E+k+1, where k is the 0-based position of that candidate in the order. Without an exact hit, `done_o` is high after edge E+4096.
- R5: If every candidate exceeds the request, `nofit_o`=1, `exact_o`=0, and `err_o`, the fields and `word_o` are 0.
- R6: `filt_o` is derived from f = ref, or ref/2 (truncated) when `pre_o`=1. The code is 7 if f≥166, 6 if f≥104, 5 if f≥65, 4 if f≥42, 3 if f≥26, 2 if f≥16, 1 if f≥10, and 0 otherwise.
- R7: `word_o` holds `filt_o` in bits 31:24 (zero-extended), `mul_o` in 23:16, `pre_o` in bit 8 and `post_o` in 2:0; all other bits are 0.
- R8: `done_o` is high for exactly one cycle. The result outputs do not change while the engine is idle and no start is applied.
- R9: `busy_o` is high from the cycle after an accepted start through the `done_o` cycle. A start that arrives while `busy_o` is high is ignored and does not affect the running search or its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, sampled while idle |
| req_rate_i | input | RATE_W | Requested output rate, MHz |
| ref_rate_i | input | RATE_W | Reference rate, MHz |
| busy_o | output | 1 | Search in progress or reporting |
| done_o | output | 1 | One-cycle completion pulse |
| mul_o | output | 8 | Chosen multiplier code |
| pre_o | output | 1 | Chosen input halver |
| post_o | output | 3 | Chosen output shift |
| filt_o | output | 3 | Loop-filter code |
| exact_o | output | 1 | Zero-error match found |
| nofit_o | output | 1 | No candidate at or below request |
| err_o | output | RATE_W | Request minus achieved rate |
| word_o | output | 32 | Packed setting word |

## Verification
The bench compares each result with a reference search, and also checks the exact number of cycles from start to done. This catches a search that visits candidates in the wrong order or fails to stop on an exact hit. A design that stops one candidate early or late, or that takes the last tied candidate instead of the first, would report the wrong setting or the wrong cycle count.

A high reference with a tiny request exercises the no-fit path. A design that leaves stale fields there would show nonzero words. The references are chosen to hit every filter threshold band, so an off-by-one comparison shows up as the wrong code. A second start injected mid-scan must leave both the result and the timing of the first request unchanged.

// File: rtl/pll_search_pkg.sv
package pll_search_pkg;
    localparam int MUL_W   = 8;
    localparam int POST_W  = 3;
    localparam int FILT_W  = 3;
    localparam int N_THRESH = 7;

    typedef enum logic [1:0] {
        S_IDLE,
        S_SCAN,
        S_REPORT
    } srch_state_e;

    typedef struct packed {
        logic [MUL_W-1:0]  mul;
        logic              pre;
        logic [POST_W-1:0] post;
    } pll_cfg_t;
endpackage

// File: rtl/pll_cand_eval.sv
module pll_cand_eval
    import pll_search_pkg::*;
#(
    parameter int RATE_W = 16
) (
    input  logic [RATE_W-1:0] ref_i,
    input  logic [RATE_W-1:0] req_i,
    input  pll_cfg_t          cfg_i,
    output logic              fits_o,
    output logic [RATE_W-1:0] err_o
);
    localparam int PROD_W = RATE_W + MUL_W + 1;
    localparam int SH_W   = POST_W + 1;

    logic [MUL_W:0]      mplus;
    logic [PROD_W-1:0]   prod;
    logic [SH_W-1:0]     shamt;
    logic [PROD_W-1:0]   freq;

    always_comb begin
        mplus  = {1'b0, cfg_i.mul} + {{MUL_W{1'b0}}, 1'b1};
        prod   = {{(MUL_W+1){1'b0}}, ref_i} * {{RATE_W{1'b0}}, mplus};
        shamt  = {1'b0, cfg_i.post} + {{POST_W{1'b0}}, cfg_i.pre};
        freq   = prod >> shamt;
        fits_o = freq <= {{(MUL_W+1){1'b0}}, req_i};
        err_o  = req_i - freq[RATE_W-1:0];
    end
endmodule

// File: rtl/pll_filter_sel.sv
module pll_filter_sel
    import pll_search_pkg::*;
#(
    parameter int RATE_W = 16
) (
    input  logic [RATE_W-1:0] ref_i,
    input  logic              pre_i,
    output logic [FILT_W-1:0] code_o
);
    localparam int unsigned BAND [N_THRESH] = '{10, 16, 26, 42, 65, 104, 166};

    logic [RATE_W-1:0]   f_in;
    logic [N_THRESH-1:0] above;

    assign f_in = pre_i ? (ref_i >> 1) : ref_i;

    for (genvar i = 0; i < N_THRESH; i++) begin : g_band
        assign above[i] = f_in >= RATE_W'(BAND[i]);
    end

    always_comb begin
        code_o = '0;
        for (int i = 0; i < N_THRESH; i++) begin
            code_o = code_o + {{(FILT_W-1){1'b0}}, above[i]};
        end
    end
endmodule

// File: rtl/pll_search_engine.sv
module pll_search_engine
    import pll_search_pkg::*;
#(
    parameter int RATE_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [RATE_W-1:0]   req_rate_i,
    input  logic [RATE_W-1:0]   ref_rate_i,
    output logic                busy_o,
    output logic                done_o,
    output logic [MUL_W-1:0]    mul_o,
    output logic                pre_o,
    output logic [POST_W-1:0]   post_o,
    output logic [FILT_W-1:0]   filt_o,
    output logic                exact_o,
    output logic                nofit_o,
    output logic [RATE_W-1:0]   err_o,
    output logic [31:0]         word_o
);
    localparam logic [MUL_W-1:0]  MUL_MAX  = {MUL_W{1'b1}};
    localparam logic [POST_W-1:0] POST_MAX = {POST_W{1'b1}};

    srch_state_e state_q, state_d;

    logic [RATE_W-1:0] req_q, ref_q;
    pll_cfg_t          cur_q, cur_nx;
    pll_cfg_t          best_q, nb_cfg;
    logic [RATE_W-1:0] best_err_q, nb_err;
    logic              best_vld_q, nb_vld;

    logic              fits;
    logic [RATE_W-1:0] cand_err;
    logic              hit_exact, better, last_cand, finish;
    logic [FILT_W-1:0] filt_nb;

    pll_cand_eval #(.RATE_W(RATE_W)) u_eval (
        .ref_i  (ref_q),
        .req_i  (req_q),
        .cfg_i  (cur_q),
        .fits_o (fits),
        .err_o  (cand_err)
    );

    pll_filter_sel #(.RATE_W(RATE_W)) u_filt (
        .ref_i  (ref_q),
        .pre_i  (nb_cfg.pre),
        .code_o (filt_nb)
    );

    always_comb begin
        hit_exact = fits && (cand_err == '0);
        better    = fits && (!best_vld_q || (cand_err < best_err_q));
        last_cand = !cur_q.pre && (cur_q.post == '0) && (cur_q.mul == MUL_MAX);
        finish    = (state_q == S_SCAN) && (hit_exact || last_cand);
        nb_cfg    = better ? cur_q : best_q;
        nb_err    = better ? cand_err : best_err_q;
        nb_vld    = best_vld_q || fits;

        cur_nx = cur_q;
        if (cur_q.mul != MUL_MAX) begin
            cur_nx.mul = cur_q.mul + 1'b1;
        end else begin
            cur_nx.mul = '0;
            if (cur_q.post != '0) begin
                cur_nx.post = cur_q.post - 1'b1;
            end else begin
                cur_nx.post = POST_MAX;
                cur_nx.pre  = 1'b0;
            end
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (start_i) state_d = S_SCAN;
            S_SCAN:   if (finish)  state_d = S_REPORT;
            S_REPORT: state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Search datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q      <= '0;
            ref_q      <= '0;
            cur_q      <= '0;
            best_q     <= '0;
            best_err_q <= '0;
            best_vld_q <= 1'b0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (start_i) begin
                        req_q      <= req_rate_i;
                        ref_q      <= ref_rate_i;
                        cur_q      <= '{mul: '0, pre: 1'b1, post: POST_MAX};
                        best_q     <= '0;
                        best_err_q <= '0;
                        best_vld_q <= 1'b0;
                    end
                end
                S_SCAN: begin
                    cur_q      <= cur_nx;
                    best_q     <= nb_cfg;
                    best_err_q <= nb_err;
                    best_vld_q <= nb_vld;
                end
                S_REPORT: ;
                default: ;
            endcase
        end
    end

    // Output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_o  <= 1'b0;
            mul_o   <= '0;
            pre_o   <= 1'b0;
            post_o  <= '0;
            filt_o  <= '0;
            exact_o <= 1'b0;
            nofit_o <= 1'b0;
            err_o   <= '0;
        end else begin
            done_o <= finish;
            if (finish) begin
                if (nb_vld) begin
                    mul_o   <= nb_cfg.mul;
                    pre_o   <= nb_cfg.pre;
                    post_o  <= nb_cfg.post;
                    filt_o  <= filt_nb;
                    exact_o <= hit_exact;
                    nofit_o <= 1'b0;
                    err_o   <= nb_err;
                end else begin
                    mul_o   <= '0;
                    pre_o   <= 1'b0;
                    post_o  <= '0;
                    filt_o  <= '0;
                    exact_o <= 1'b0;
                    nofit_o <= 1'b1;
                    err_o   <= '0;
                end
            end
        end
    end

    assign busy_o = (state_q != S_IDLE);
    assign word_o = {{(8-FILT_W){1'b0}}, filt_o, mul_o, 7'b0, pre_o, 5'b0, post_o};
endmodule

// File: rtl/pll_search_chk.sv
module pll_search_chk
    import pll_search_pkg::*;
#(
    parameter int RATE_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              busy_o,
    input logic              done_o,
    input logic [MUL_W-1:0]  mul_o,
    input logic              pre_o,
    input logic [POST_W-1:0] post_o,
    input logic              exact_o,
    input logic              nofit_o,
    input logic [RATE_W-1:0] err_o,
    input logic [31:0]       word_o,
    input logic [RATE_W-1:0] req_q,
    input logic [RATE_W-1:0] ref_q
);
    localparam int PW = RATE_W + MUL_W + 1;

    logic [PW-1:0] achieved;
    logic [PW-1:0] target;

    always_comb begin
        achieved = ({{(MUL_W+1){1'b0}}, ref_q} * PW'({1'b0, mul_o} + 1'b1))
                   >> ({1'b0, post_o} + {3'b0, pre_o});
        target   = {{(MUL_W+1){1'b0}}, req_q} - {{(MUL_W+1){1'b0}}, err_o};
    end

    assert_rate_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !nofit_o) |-> (achieved == target && err_o <= req_q));

    assert_exact_zero_err_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && exact_o) |-> (err_o == '0));

    assert_nofit_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && nofit_o) |-> (word_o == '0 && !exact_o && err_o == '0));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_idle_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(word_o) && $stable(err_o));

    assert_busy_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));

    assert_done_in_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> busy_o);
endmodule

bind pll_search_engine pll_search_chk #(.RATE_W(RATE_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .mul_o   (mul_o),
    .pre_o   (pre_o),
    .post_o  (post_o),
    .exact_o (exact_o),
    .nofit_o (nofit_o),
    .err_o   (err_o),
    .word_o  (word_o),
    .req_q   (req_q),
    .ref_q   (ref_q)
);

// File: tb/tb_pll_search_engine.sv
module tb_pll_search_engine;
    localparam int RATE_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [RATE_W-1:0] req_rate_i = '0;
    logic [RATE_W-1:0] ref_rate_i = '0;
    logic              busy_o, done_o, pre_o, exact_o, nofit_o;
    logic [7:0]        mul_o;
    logic [2:0]        post_o, filt_o;
    logic [RATE_W-1:0] err_o;
    logic [31:0]       word_o;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    pll_search_engine #(.RATE_W(RATE_W)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .req_rate_i(req_rate_i), .ref_rate_i(ref_rate_i),
        .busy_o(busy_o), .done_o(done_o), .mul_o(mul_o), .pre_o(pre_o),
        .post_o(post_o), .filt_o(filt_o), .exact_o(exact_o),
        .nofit_o(nofit_o), .err_o(err_o), .word_o(word_o)
    );

    task automatic check(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int filt_model(input int rf, input int h);
        int f = h ? rf / 2 : rf;
        if (f >= 166) return 7;
        if (f >= 104) return 6;
        if (f >= 65)  return 5;
        if (f >= 42)  return 4;
        if (f >= 26)  return 3;
        if (f >= 16)  return 2;
        if (f >= 10)  return 1;
        return 0;
    endfunction

    task automatic model(input int rf, input int rq, output int m, output int h,
                         output int s, output int e, output bit ex, output bit nf,
                         output int cyc);
        int best = -1;
        int k = 0;
        m = 0; h = 0; s = 0; e = 0; ex = 0; nf = 1; cyc = 4096;
        for (int hh = 1; hh >= 0; hh--) begin
            for (int ss = 7; ss >= 0; ss--) begin
                for (int mm = 0; mm <= 255; mm++) begin
                    int f = (rf * (mm + 1)) >>> (hh + ss);
                    if (f <= rq) begin
                        int er = rq - f;
                        if (best < 0 || er < best) begin
                            best = er; m = mm; h = hh; s = ss; e = er; nf = 0;
                        end
                        if (er == 0) begin
                            ex = 1; cyc = k + 1;
                            return;
                        end
                    end
                    k++;
                end
            end
        end
    endtask

    // Issue a start, wait for done, count cycles; optional interfering start.
    task automatic launch(input int rf, input int rq, input int poke_at,
                          output int cyc);
        @(negedge clk);
        ref_rate_i = RATE_W'(rf);
        req_rate_i = RATE_W'(rq);
        start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        cyc = 0;
        forever begin
            if (cyc == poke_at) begin
                start_i = 1'b1;
                ref_rate_i = 16'd1000;
                req_rate_i = 16'd2;
            end
            @(posedge clk);
            cyc++;
            @(negedge clk);
            start_i = 1'b0;
            if (done_o) break;
        end
    endtask

    task automatic verify(input string tag, input int rf, input int rq,
                          input int cyc);
        int m, h, s, e, fc, cexp;
        bit ex, nf;
        model(rf, rq, m, h, s, e, ex, nf, cexp);
        fc = nf ? 0 : filt_model(rf, h);
        check({tag, " R4 cycles"}, cyc, cexp);
        check({tag, " R4 exact"}, exact_o, ex);
        check({tag, " R5 nofit"}, nofit_o, nf);
        check({tag, " R3 mul"}, mul_o, nf ? 0 : m);
        check({tag, " R3 pre"}, pre_o, nf ? 0 : h);
        check({tag, " R3 post"}, post_o, nf ? 0 : s);
        check({tag, " R2 err"}, err_o, nf ? 0 : e);
        check({tag, " R6 filter"}, filt_o, fc);
        check({tag, " R7 word"}, word_o,
              nf ? 0 : ((fc << 24) | (m << 16) | (h << 8) | s));
        check({tag, " R9 busy at done"}, busy_o, 1);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 busy", busy_o, 0);
        check("R1 done", done_o, 0);
        check("R1 word", word_o, 0);
        check("R1 err", err_o, 0);
        check("R1 flags", {exact_o, nofit_o}, 0);
    endtask

    task automatic t_exact();
        int c;
        launch(25, 400, -1, c);
        verify("exact 25/400", 25, 400, c);
    endtask

    task automatic t_inexact();
        int c;
        launch(27, 1000, -1, c);
        verify("best-lower 27/1000", 27, 1000, c);
        launch(7, 33331, -1, c);
        verify("best-lower 7/33331", 7, 33331, c);
    endtask

    task automatic t_nofit();
        int c;
        launch(1000, 2, -1, c);
        verify("nofit 1000/2", 1000, 2, c);
    endtask

    task automatic t_filter_bands();
        int refs [9] = '{9, 20, 33, 60, 84, 130, 210, 340, 50};
        foreach (refs[i]) begin
            int c;
            launch(refs[i], refs[i] * 4, -1, c);
            verify($sformatf("R6 band ref=%0d", refs[i]), refs[i], refs[i] * 4, c);
        end
    endtask

    task automatic t_busy_start();
        int c;
        launch(25, 400, 100, c);
        verify("R9 ignored start", 25, 400, c);
    endtask

    task automatic t_done_hold();
        logic [31:0] w;
        int c;
        launch(27, 1000, -1, c);
        w = word_o;
        @(negedge clk);
        check("R8 done one cycle", done_o, 0);
        check("R9 busy dropped", busy_o, 0);
        repeat (5) @(negedge clk);
        check("R8 word held", word_o, w);
    endtask

    task automatic finish_up();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_exact();
        t_inexact();
        t_nofit();
        t_filter_bands();
        t_busy_start();
        t_done_hold();
        finish_up();
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end
endmodule